// File: doc/BRIEF.md
# Hot-Swap Card Power Sequencer

This block sequences power for an add-in card that can be plugged into or pulled out of a running host. It works on already-digitized inputs. Two active-low seating contacts say the card is in the connector. Four supply-good flags report the host and card 5 V and 3.3 V rails. A host power-enable input lets the host gate power to the card. A host reset input lets the host restart the card logic, and a strap picks which rails are watched. The block drives one enable for each external power switch, a driver-enable, a card-voltage-valid flag, a signals-valid flag, and a pair of complementary reset outputs.

Insertion is accepted only after both seating contacts have been steady for a filter window. The power switches turn on once the host allows it and the watched host rails are good. Card logic is then held in reset for a power-up delay, counted from the moment the card rails are good. After that the resets release and signals-valid follows. A failing host rail, a failing card rail, a lost seating contact and a host reset each act on the outputs differently. A host reset only stretches the resets and leaves the power path alone. All window lengths are cycle counts set by parameters.

Top module: `hotswap_seq_ctrl`

## Requirements
- R1: The card counts as seated only after both `det_a_n` and `det_b_n` have been sampled low on FILT_CYC consecutive clock edges. Any high sample restarts the count. With all other conditions met, the switch enables turn on at the edge after the FILT_CYC-th low sample.
- R2: While `host_pwr_en` is 0, the switch enables and `drv_en` stay 0 and the resets stay asserted.
- R3: With `vsel_3v3_only` = 0, both `host5_good` and `host3_good` must be 1 to enable the switches, and both card flags must be 1 for card-voltage-valid. With `vsel_3v3_only` = 1, only the 3.3 V flags are used.
- R4: `gate5_en`, `gate3_en` and `drv_en` switch together, at the edge after the seating, host-enable and host-rail conditions all hold.
- R5: `card_v_ok` is 1 exactly when the switches are on (or turning on at that edge) and the watched card rails are good. The resets release POR_CYC edges after the first edge that samples `card_v_ok` = 1.
- R6: `sig_valid` rises at the edge after the resets release, and only while the switches are on. It drops in the same cycle the resets assert.
- R7: If a watched host rail goes bad, the next edge turns off all three enables and asserts the resets.
- R8: If only a watched card rail goes bad, the next edge clears `card_v_ok` and asserts the resets. The enables stay on.
- R9: If either seating contact reads high, the next edge turns off the enables, `card_v_ok` and `sig_valid` and asserts the resets.
- R10: A low on `host_rst_n` that lasts fewer than GLITCH_CYC consecutive sampled edges has no effect on the resets.
- R11: A low on `host_rst_n` that is sampled on GLITCH_CYC edges asserts the resets at that GLITCH_CYC-th edge. They then stay asserted for POR_CYC edges or until the edge that samples `host_rst_n` high again, whichever is later. The enables do not change.
- R12: While `rst_n` is 0, all enables, `card_v_ok` and `sig_valid` are 0, `rst_out` is 1 and `rst_out_n` is 0. `rst_out_n` is always the complement of `rst_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| det_a_n | input | 1 | First seating contact, low when seated |
| det_b_n | input | 1 | Second seating contact, low when seated |
| host_pwr_en | input | 1 | Host permission to power the card |
| host_rst_n | input | 1 | Host reset request, active low |
| vsel_3v3_only | input | 1 | 1: watch 3.3 V rails only; 0: watch 5 V and 3.3 V |
| host5_good | input | 1 | Host 5 V rail above threshold |
| host3_good | input | 1 | Host 3.3 V rail above threshold |
| card5_good | input | 1 | Card 5 V rail above threshold |
| card3_good | input | 1 | Card 3.3 V rail above threshold |
| gate5_en | output | 1 | Enable for the 5 V power switch |
| gate3_en | output | 1 | Enable for the 3.3 V power switch |
| drv_en | output | 1 | Driver enable, follows the switch enables |
| card_v_ok | output | 1 | Card-voltage-valid, active high |
| sig_valid | output | 1 | Signals-valid, active high |
| rst_out | output | 1 | Card reset, active high |
| rst_out_n | output | 1 | Card reset, active low |

## Verification
The steady-state decision is swept over all 64 combinations of strap, host-enable and the four rail flags. This separates the 5 V-and-3.3 V rule from the 3.3 V-only rule, and separates host-rail faults, which remove power, from card-rail faults, which only hold reset. Directed sequences then count edges. A seating bounce one sample short of the filter window shows the count restarts. Card-rail, host-rail and seating losses each produce a distinct pattern of outputs. Host reset pulses one sample short of, exactly at, and far beyond the glitch window tell apart the ignored case, the timer-limited stretch and the pulse-limited stretch.

// File: rtl/hsw_pkg.sv
// Shared types and helpers for the hot-swap power sequencer.
package hsw_pkg;

    // Power path state, in the order a card normally walks through it.
    typedef enum logic [1:0] {
        PS_EMPTY      = 2'd0,
        PS_WAIT_HOST  = 2'd1,
        PS_WAIT_RAILS = 2'd2,
        PS_ON         = 2'd3
    } pwr_state_e;

    // True when the watched pair of rails is good under the strap setting.
    function automatic logic rails_good(input logic only3, input logic good5,
                                        input logic good3);
        return good3 && (only3 || good5);
    endfunction

endpackage

// File: rtl/hsw_pin_filter.sv
// Seating filter: reports the card as present once both active-low contacts
// have been sampled low on FILT_CYC consecutive edges. Removal acts at once.
// Assumes the contacts are already synchronised to clk.
module hsw_pin_filter #(
    parameter int FILT_CYC = 15_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_a_n,
    input  logic det_b_n,
    output logic present
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic          both_low;
    logic [CW-1:0] run_cnt;
    logic          seated_q;

    assign both_low = !det_a_n && !det_b_n;

    // Count consecutive seated samples; any open contact clears the count.
    always_ff @(posedge clk) begin
        if (!rst_n || !both_low) begin
            run_cnt  <= '0;
            seated_q <= 1'b0;
        end else if (!seated_q) begin
            if (run_cnt == CW'(FILT_CYC - 1)) begin
                seated_q <= 1'b1;
            end else begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end

    assign present = seated_q && both_low;

endmodule

// File: rtl/hsw_host_rst_filter.sv
// Host reset conditioner: rejects lows shorter than GLITCH_CYC sampled edges.
// An accepted low holds the card reset for HOLD_CYC edges or for as long as
// the input stays low, whichever is later. Assumes a synchronised input.
module hsw_host_rst_filter #(
    parameter int GLITCH_CYC = 4,
    parameter int HOLD_CYC   = 13_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_rst_n,
    output logic hold
);
    localparam int LW = $clog2(GLITCH_CYC + 1);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [LW-1:0] low_cnt;
    logic          accepted_q;
    logic [HW-1:0] hold_left;
    logic          accept_now;

    assign accept_now = !host_rst_n && (low_cnt == LW'(GLITCH_CYC - 1));

    // Measure the low pulse and flag it once it outlasts the glitch window.
    always_ff @(posedge clk) begin
        if (!rst_n || host_rst_n) begin
            low_cnt    <= '0;
            accepted_q <= 1'b0;
        end else if (accept_now) begin
            accepted_q <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Minimum-length timer, loaded when a pulse is first accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_left <= '0;
        end else if (accept_now && !accepted_q) begin
            hold_left <= HW'(HOLD_CYC);
        end else if (hold_left != '0) begin
            hold_left <= hold_left - 1'b1;
        end
    end

    assign hold = accepted_q || (hold_left != '0);

endmodule

// File: rtl/hsw_por_timer.sv
// Power-up reset delay: done rises at the POR_CYC-th consecutive edge that
// samples power_ok high, and clears on the first edge that samples it low.
module hsw_por_timer #(
    parameter int POR_CYC = 13_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic power_ok,
    output logic done
);
    localparam int PW = $clog2(POR_CYC + 1);

    logic [PW-1:0] cnt;

    // Count good-power edges; restart whenever power is lost.
    always_ff @(posedge clk) begin
        if (!rst_n || !power_ok) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (cnt == PW'(POR_CYC - 1)) begin
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hsw_power_fsm.sv
// Power path control: decides from seating, host permission and host rails
// whether the switches are on, and flags the card rails as valid only while
// they are. The decision is flat, so any failed condition acts on the next edge.
module hsw_power_fsm
    import hsw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic present,
    input  logic pwr_allow,
    input  logic host_ok,
    input  logic card_ok,
    output logic gate_on,
    output logic card_valid
);
    pwr_state_e state_q;
    pwr_state_e state_d;

    // Next state: the first unmet condition names where the card waits.
    always_comb begin
        if (!present) begin
            state_d = PS_EMPTY;
        end else if (!pwr_allow) begin
            state_d = PS_WAIT_HOST;
        end else if (!host_ok) begin
            state_d = PS_WAIT_RAILS;
        end else begin
            state_d = PS_ON;
        end
    end

    // State and card-valid registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= PS_EMPTY;
            card_valid <= 1'b0;
        end else begin
            state_q    <= state_d;
            card_valid <= (state_d == PS_ON) && card_ok;
        end
    end

    assign gate_on = (state_q == PS_ON);

endmodule

// File: rtl/hotswap_seq_ctrl.sv
// Hot-swap card power sequencer top. Combines the seating filter, power path
// control, power-up delay and host reset conditioner into the card outputs.
// Assumes all inputs are synchronous to clk; levels are logical (1 = true)
// except the contacts, host_rst_n and rst_out_n.
module hotswap_seq_ctrl
    import hsw_pkg::*;
#(
    parameter int FILT_CYC   = 15_000_000,
    parameter int GLITCH_CYC = 4,
    parameter int POR_CYC    = 13_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_a_n,
    input  logic det_b_n,
    input  logic host_pwr_en,
    input  logic host_rst_n,
    input  logic vsel_3v3_only,
    input  logic host5_good,
    input  logic host3_good,
    input  logic card5_good,
    input  logic card3_good,
    output logic gate5_en,
    output logic gate3_en,
    output logic drv_en,
    output logic card_v_ok,
    output logic sig_valid,
    output logic rst_out,
    output logic rst_out_n
);
    logic present;
    logic host_ok;
    logic card_ok;
    logic gate_on;
    logic card_valid;
    logic por_done;
    logic host_hold;
    logic rst_active;
    logic sv_q;

    assign host_ok = rails_good(vsel_3v3_only, host5_good, host3_good);
    assign card_ok = rails_good(vsel_3v3_only, card5_good, card3_good);

    hsw_pin_filter #(.FILT_CYC(FILT_CYC)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .det_a_n (det_a_n),
        .det_b_n (det_b_n),
        .present (present)
    );

    hsw_power_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .present    (present),
        .pwr_allow  (host_pwr_en),
        .host_ok    (host_ok),
        .card_ok    (card_ok),
        .gate_on    (gate_on),
        .card_valid (card_valid)
    );

    hsw_por_timer #(.POR_CYC(POR_CYC)) u_por (
        .clk      (clk),
        .rst_n    (rst_n),
        .power_ok (card_valid),
        .done     (por_done)
    );

    hsw_host_rst_filter #(.GLITCH_CYC(GLITCH_CYC), .HOLD_CYC(POR_CYC)) u_hrst (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rst_n (host_rst_n),
        .hold       (host_hold)
    );

    assign rst_active = !por_done || !card_valid || host_hold;

    // Signals-valid follows reset release by one edge while power is on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_q <= 1'b0;
        end else begin
            sv_q <= gate_on && !rst_active;
        end
    end

    assign gate5_en  = gate_on;
    assign gate3_en  = gate_on;
    assign drv_en    = gate_on;
    assign card_v_ok = card_valid;
    assign sig_valid = sv_q && !rst_active;
    assign rst_out   = rst_active;
    assign rst_out_n = !rst_active;

endmodule

// File: rtl/hsw_checker.sv
// Property checker for the hot-swap sequencer, bound to every instance.
module hsw_checker #(
    parameter int FILT_CYC = 8
) (
    input logic clk,
    input logic rst_n,
    input logic det_a_n,
    input logic det_b_n,
    input logic host_pwr_en,
    input logic host3_good,
    input logic host5_good,
    input logic vsel_3v3_only,
    input logic gate5_en,
    input logic drv_en,
    input logic card_v_ok,
    input logic sig_valid,
    input logic rst_out
);
    localparam int LW = $clog2(FILT_CYC + 2);

    logic [LW-1:0] low_run;

    // Independent count of consecutive seated samples, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || det_a_n || det_b_n) begin
            low_run <= '0;
        end else if (low_run != LW'(FILT_CYC + 1)) begin
            low_run <= low_run + 1'b1;
        end
    end

    assert_gate_needs_filter_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate5_en) |-> (low_run >= LW'(FILT_CYC)));

    assert_gate_needs_host_R2: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> $past(host_pwr_en));

    assert_host_rails_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate5_en |-> $past(host3_good && (vsel_3v3_only || host5_good)));

    assert_cardv_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        card_v_ok |-> gate5_en);

    assert_release_needs_cardv_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> card_v_ok);

    assert_sigvalid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid |-> (!rst_out && drv_en));

    assert_host3_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !host3_good |=> !gate5_en);

    assert_pin_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (det_a_n || det_b_n) |=> (!gate5_en && !sig_valid && rst_out));

endmodule

bind hotswap_seq_ctrl hsw_checker #(.FILT_CYC(FILT_CYC)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .det_a_n       (det_a_n),
    .det_b_n       (det_b_n),
    .host_pwr_en   (host_pwr_en),
    .host3_good    (host3_good),
    .host5_good    (host5_good),
    .vsel_3v3_only (vsel_3v3_only),
    .gate5_en      (gate5_en),
    .drv_en        (drv_en),
    .card_v_ok     (card_v_ok),
    .sig_valid     (sig_valid),
    .rst_out       (rst_out)
);

// File: tb/sim_hotswap_seq_ctrl.sv
module sim_hotswap_seq_ctrl;
    localparam int FILT = 8;
    localparam int GLT  = 3;
    localparam int POR  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_a_n = 1'b1, det_b_n = 1'b1;
    logic host_pwr_en = 1'b1, host_rst_n = 1'b1, vsel = 1'b0;
    logic h5 = 1'b1, h3 = 1'b1, c5 = 1'b1, c3 = 1'b1;
    logic gate5_en, gate3_en, drv_en, card_v_ok, sig_valid, rst_out, rst_out_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    hotswap_seq_ctrl #(.FILT_CYC(FILT), .GLITCH_CYC(GLT), .POR_CYC(POR)) u0 (
        .clk(clk), .rst_n(rst_n), .det_a_n(det_a_n), .det_b_n(det_b_n),
        .host_pwr_en(host_pwr_en), .host_rst_n(host_rst_n), .vsel_3v3_only(vsel),
        .host5_good(h5), .host3_good(h3), .card5_good(c5), .card3_good(c3),
        .gate5_en(gate5_en), .gate3_en(gate3_en), .drv_en(drv_en),
        .card_v_ok(card_v_ok), .sig_valid(sig_valid),
        .rst_out(rst_out), .rst_out_n(rst_out_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        tick(3);
        // R12 reset state
        chk("R12 gate5", gate5_en, 1'b0);
        chk("R12 drv", drv_en, 1'b0);
        chk("R12 cardv", card_v_ok, 1'b0);
        chk("R12 sigv", sig_valid, 1'b0);
        chk("R12 rst", rst_out, 1'b1);
        chk("R12 rst_n", rst_out_n, 1'b0);
        rst_n = 1'b1;

        // R1 bounce: one sample short, then a high sample restarts the count
        det_a_n = 1'b0; det_b_n = 1'b0;
        tick(FILT - 1);
        chk("R1 short run", gate5_en, 1'b0);
        det_a_n = 1'b1;
        tick(1);
        det_a_n = 1'b0;
        tick(FILT);
        chk("R1 full run not yet", gate5_en, 1'b0);
        tick(1);
        chk("R1 gate on", gate5_en, 1'b1);
        chk("R4 gate3", gate3_en, 1'b1);
        chk("R4 drv", drv_en, 1'b1);
        chk("R5 cardv", card_v_ok, 1'b1);
        tick(POR - 1);
        chk("R5 rst still held", rst_out, 1'b1);
        tick(1);
        chk("R5 rst released", rst_out, 1'b0);
        chk("R6 sigv lags", sig_valid, 1'b0);
        tick(1);
        chk("R6 sigv up", sig_valid, 1'b1);

        // R10 host reset shorter than the glitch window
        host_rst_n = 1'b0;
        tick(GLT - 1);
        host_rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R10 glitch ignored", rst_out, 1'b0);
        end

        // R11 pulse exactly the glitch window: timer-limited stretch
        host_rst_n = 1'b0;
        tick(GLT - 1);
        chk("R11 before accept", rst_out, 1'b0);
        tick(1);
        chk("R11 accepted", rst_out, 1'b1);
        chk("R6 sigv drops with rst", sig_valid, 1'b0);
        host_rst_n = 1'b1;
        tick(POR - 1);
        chk("R11 timer holds", rst_out, 1'b1);
        chk("R11 gates kept", gate5_en, 1'b1);
        tick(1);
        chk("R11 timer end", rst_out, 1'b0);
        tick(1);
        chk("R6 sigv back", sig_valid, 1'b1);

        // R11 long pulse: pulse-limited stretch
        host_rst_n = 1'b0;
        tick(POR + 6);
        chk("R11 long held", rst_out, 1'b1);
        chk("R11 long gates kept", drv_en, 1'b1);
        host_rst_n = 1'b1;
        tick(1);
        chk("R11 long release", rst_out, 1'b0);
        tick(1);

        // R8 card rail loss only
        c3 = 1'b0;
        tick(1);
        chk("R8 cardv off", card_v_ok, 1'b0);
        chk("R8 rst", rst_out, 1'b1);
        chk("R8 rst_n", rst_out_n, 1'b0);
        chk("R8 gates stay", gate5_en, 1'b1);
        chk("R8 sigv off", sig_valid, 1'b0);
        c3 = 1'b1;
        tick(1);
        chk("R5 cardv back", card_v_ok, 1'b1);
        tick(POR - 1);
        chk("R5 restart held", rst_out, 1'b1);
        tick(1);
        chk("R5 restart release", rst_out, 1'b0);
        tick(2);

        // R7 host rail loss
        h5 = 1'b0;
        tick(1);
        chk("R7 gate5 off", gate5_en, 1'b0);
        chk("R7 drv off", drv_en, 1'b0);
        chk("R7 rst", rst_out, 1'b1);
        chk("R7 sigv", sig_valid, 1'b0);
        h5 = 1'b1;
        tick(1);
        chk("R4 gates back", gate3_en, 1'b1);
        tick(POR + 3);

        // R9 seating loss
        det_b_n = 1'b1;
        tick(1);
        chk("R9 gates off", gate5_en, 1'b0);
        chk("R9 cardv off", card_v_ok, 1'b0);
        chk("R9 sigv off", sig_valid, 1'b0);
        chk("R9 rst", rst_out, 1'b1);
        det_b_n = 1'b0;
        tick(FILT + 2);

        // Sweep strap, host enable and rail flags in steady state (R2 R3 R5 R6)
        for (int k = 0; k < 64; k++) begin
            logic ex_on, ex_cv;
            vsel = k[5]; host_pwr_en = k[4];
            h5 = k[3]; h3 = k[2]; c5 = k[1]; c3 = k[0];
            ex_on = k[4] && k[2] && (k[5] || k[3]);
            ex_cv = ex_on && k[0] && (k[5] || k[1]);
            tick(POR + 4);
            chk("R2 R3 sweep gate", gate5_en, ex_on);
            chk("R3 R5 sweep cardv", card_v_ok, ex_cv);
            chk("R2 R5 sweep rst", rst_out, !ex_cv);
            chk("R6 sweep sigv", sig_valid, ex_cv);
        end

        summary();
    end

endmodule